// File: doc/BRIEF.md
# Console receive register interface

This block is the software-facing side of a console receiver. It holds exactly one received character, together with error flags, in a 16-bit data register. A status register reports whether a character is waiting and whether interrupts are enabled. An upstream receiver presents each character as a one-cycle strobe with eight data bits and a break flag. Software reaches both registers over a simple single-cycle register bus and sees an interrupt request level. When a break arrives and an external enable allows it, the block also issues a halt request.

Reading the data register is the acknowledge. That single access returns the whole word, including the error flags, and at the clock edge that ends it clears the waiting flag, strips the error bits and drops the interrupt. A mode input selects 7-bit or 8-bit character handling. If a new character arrives before the previous one was read, it replaces the old one and is marked as an overrun.

Top module: `con_rx_regs`

## Requirements
- R1: After reset, and after any later reset, both registers read 0x0000 and `irq_o` and `halt_o` are low.
- R2: The status register (`reg_sel_i`=0) has a ready flag at bit 7 and an interrupt enable at bit 6, and all other bits read as zero. A write changes only the enable bit. The ready flag ignores writes.
- R3: A character strobe stores the character in data bits 7:0 with bits 15:8 zero and sets the ready flag at the next clock edge.
- R4: With `mode_8b_i`=0 the stored bit 7 is forced to zero. With `mode_8b_i`=1 all eight bits are kept.
- R5: A strobe with `rx_break_i` high loads the data register with exactly 0xA400 (bit 15 error summary, bit 13 framing, bit 10 break; character byte zero) and sets the ready flag.
- R6: `halt_o` goes high for one cycle after a break strobe, and only if `halt_en_i` was high with that strobe.
- R7: A non-break strobe that arrives while the ready flag is set and no data read happens in the same cycle stores the new character with bit 15 (error summary) and bit 14 (overrun) set.
- R8: A data read (`reg_sel_i`=1) returns the full 16-bit word. After that edge the ready flag is clear, bits 15:8 are zero and `irq_o` is low.
- R9: `irq_o` rises one cycle after a strobe if the enable is set, and it stays high until a data read or an enable-clearing write.
- R10: Writing the enable as 0 drops `irq_o` at the next edge. Writing it as 1 while the ready flag is set raises `irq_o` at the next edge.
- R11: If a strobe and a data read happen in the same cycle, the read returns the old word. The new character is then stored with the ready flag set and no overrun bits.
- R12: Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a character or break is presented |
| rx_data_i | input | 8 | Received character |
| rx_break_i | input | 1 | Qualifies the strobe as a break condition |
| mode_8b_i | input | 1 | 1: keep 8 bits, 0: force bit 7 to zero |
| halt_en_i | input | 1 | Allows a break to request a halt |
| reg_sel_i | input | 1 | Register select: 0 status, 1 data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; side effects at the clock edge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational while `reg_rd_i` is high, else zero |
| irq_o | output | 1 | Interrupt request level |
| halt_o | output | 1 | One-cycle halt request |

## Verification
Every piece of state in this block can be seen from the register bus within one access. The ready flag and the enable show up in the next status read. A stale error bit shows up in the next data read. A stuck or late interrupt shows up on `irq_o` one edge after the strobe, read or write that should have changed it. The stimulus reads the data word twice in a row after an overrun and after a break, so a read that fails to strip the high byte is caught on the second read. A same-cycle strobe and read is followed by a status read and a data read. This separates "arrival wins" from "read wins", and from a spurious overrun.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
  localparam int DATA_W   = 16;
  localparam int CHAR_W   = 8;
  localparam int ERR_BIT  = 15;
  localparam int OVR_BIT  = 14;
  localparam int FRM_BIT  = 13;
  localparam int BRK_BIT  = 10;
  localparam int RDY_BIT  = 7;
  localparam int IE_BIT   = 6;
  localparam int HIGH_W   = DATA_W - CHAR_W;

  localparam logic [DATA_W-1:0] BRK_WORD =
    (DATA_W'(1) << ERR_BIT) | (DATA_W'(1) << FRM_BIT) | (DATA_W'(1) << BRK_BIT);
  localparam logic [DATA_W-1:0] OVR_WORD =
    (DATA_W'(1) << ERR_BIT) | (DATA_W'(1) << OVR_BIT);
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << RDY_BIT) | (DATA_W'(1) << IE_BIT);

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/con_rx_capture.sv
module con_rx_capture
  import con_rx_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int DW = DATA_W
) (
  input  logic          brk_i,
  input  logic [CW-1:0] char_i,
  input  logic          mode_full_i,
  input  logic          rdy_i,
  input  logic          rd_data_i,
  output logic [DW-1:0] word_o
);
  localparam int PAD_W = DW - CW;

  logic [CW-1:0] char_m;
  logic          ovr;

  generate
    if (CW > 1) begin : g_mask
      assign char_m = mode_full_i ? char_i : {1'b0, char_i[CW-2:0]};
    end else begin : g_nomask
      assign char_m = mode_full_i ? char_i : '0;
    end
  endgenerate

  // overrun only if the old character is not being consumed this cycle
  assign ovr = rdy_i & ~rd_data_i;

  always_comb begin
    if (brk_i) word_o = BRK_WORD;
    else begin
      word_o = {{PAD_W{1'b0}}, char_m};
      if (ovr) word_o = word_o | OVR_WORD;
    end
  end
endmodule

// File: rtl/con_rx_state.sv
module con_rx_state
  import con_rx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHAR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          brk_i,
  input  logic          halt_en_i,
  input  logic [DW-1:0] word_i,
  input  logic          st_wr_i,
  input  logic          st_ie_i,
  input  logic          dt_rd_i,
  output logic          rdy_o,
  output logic          ie_o,
  output logic [DW-1:0] buf_o,
  output logic          irq_o,
  output logic          halt_o
);
  logic          rdy_q, ie_q, irq_q, halt_q;
  logic [DW-1:0] buf_q;
  logic          rdy_n, ie_n;
  logic [DW-1:0] buf_n;

  always_comb begin
    ie_n  = st_wr_i ? st_ie_i : ie_q;
    rdy_n = rdy_q;
    buf_n = buf_q;
    if (strobe_i) begin
      rdy_n = 1'b1;
      buf_n = word_i;
    end else if (dt_rd_i) begin
      rdy_n = 1'b0;
      buf_n = {{(DW-CW){1'b0}}, buf_q[CW-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      rdy_q  <= rdy_n;
      ie_q   <= ie_n;
      buf_q  <= buf_n;
      irq_q  <= rdy_n & ie_n;
      halt_q <= strobe_i & brk_i & halt_en_i;
    end
  end

  assign rdy_o  = rdy_q;
  assign ie_o   = ie_q;
  assign buf_o  = buf_q;
  assign irq_o  = irq_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/con_rx_rdmux.sv
module con_rx_rdmux
  import con_rx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          rd_i,
  input  logic          sel_i,
  input  logic          rdy_i,
  input  logic          ie_i,
  input  logic [DW-1:0] buf_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] status_w;

  always_comb begin
    status_w          = '0;
    status_w[RDY_BIT] = rdy_i;
    status_w[IE_BIT]  = ie_i;
  end

  always_comb begin
    if (!rd_i)                      rdata_o = '0;
    else if (sel_i == SEL_DATA)     rdata_o = buf_i;
    else                            rdata_o = status_w;
  end
endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
  import con_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_break_i,
  input  logic              mode_8b_i,
  input  logic              halt_en_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              halt_o
);
  logic              st_wr, dt_rd;
  logic              rdy_w, ie_w;
  logic [DATA_W-1:0] buf_w, word_w;

  assign st_wr = reg_wr_i & (reg_sel_i == SEL_STATUS);
  assign dt_rd = reg_rd_i & (reg_sel_i == SEL_DATA);

  con_rx_capture #(.CW(CHAR_W), .DW(DATA_W)) u_cap (
    .brk_i       (rx_break_i),
    .char_i      (rx_data_i),
    .mode_full_i (mode_8b_i),
    .rdy_i       (rdy_w),
    .rd_data_i   (dt_rd),
    .word_o      (word_w)
  );

  con_rx_state #(.DW(DATA_W), .CW(CHAR_W)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (rx_valid_i),
    .brk_i     (rx_break_i),
    .halt_en_i (halt_en_i),
    .word_i    (word_w),
    .st_wr_i   (st_wr),
    .st_ie_i   (reg_wdata_i[IE_BIT]),
    .dt_rd_i   (dt_rd),
    .rdy_o     (rdy_w),
    .ie_o      (ie_w),
    .buf_o     (buf_w),
    .irq_o     (irq_o),
    .halt_o    (halt_o)
  );

  con_rx_rdmux #(.DW(DATA_W)) u_mux (
    .rd_i    (reg_rd_i),
    .sel_i   (reg_sel_i),
    .rdy_i   (rdy_w),
    .ie_i    (ie_w),
    .buf_i   (buf_w),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/con_rx_regs_chk.sv
module con_rx_regs_chk
  import con_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_break_i,
  input logic              mode_8b_i,
  input logic              halt_en_i,
  input logic              reg_sel_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic              wdata_ie_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic              halt_o,
  input logic              rdy_i,
  input logic [DATA_W-1:0] buf_i
);
  a_r2_status_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_sel_i) |-> ((reg_rdata_o & ~STATUS_MASK) == '0));

  a_r3_rdy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rdy_i);

  a_r4_seven_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_break_i && !mode_8b_i) |=> !buf_i[CHAR_W-1]);

  a_r5_break_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_break_i) |=> (buf_i == BRK_WORD));

  a_r6_halt_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(rx_valid_i && rx_break_i && halt_en_i));

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i && !rx_valid_i) |=>
      (!rdy_i && !irq_o && buf_i[DATA_W-1:CHAR_W] == '0));

  a_r9_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_rd_i && reg_sel_i) && !(reg_wr_i && !reg_sel_i)) |=> irq_o);

  a_r10_ie_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_sel_i && !wdata_ie_i) |=> !irq_o);
endmodule

bind con_rx_regs con_rx_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_break_i  (rx_break_i),
  .mode_8b_i   (mode_8b_i),
  .halt_en_i   (halt_en_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .wdata_ie_i  (reg_wdata_i[con_rx_pkg::IE_BIT]),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .halt_o      (halt_o),
  .rdy_i       (rdy_w),
  .buf_i       (buf_w)
);

// File: tb/sim_con_rx_regs.sv
module sim_con_rx_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  typedef struct packed {
    logic [3:0]  req;
    logic        vld, brk, m8, hen;
    logic [7:0]  d;
    logic        sel, wr, rd;
    logic [15:0] wd;
    logic [15:0] erd;
    logic        eirq, ehalt;
  } vec_t;

  // fields: req vld brk m8 hen d sel wr rd wd erd eirq ehalt
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0,1'b1, 16'h0000, 16'h0000, 1'b0,1'b0}, // R1 status
    '{4'd1, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'h0000, 1'b0,1'b0}, // R1 data
    '{4'd2, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b1,1'b0, 16'hFFFF, 16'h0000, 1'b0,1'b0}, // R2 write all ones
    '{4'd2, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0,1'b1, 16'h0000, 16'h0040, 1'b0,1'b0}, // R2 only enable set
    '{4'd3, 1'b1,1'b0,1'b1,1'b0, 8'h41, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b1,1'b0}, // R3 char, irq
    '{4'd2, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0,1'b1, 16'h0000, 16'h00C0, 1'b1,1'b0}, // R2 ready+enable
    '{4'd9, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b1,1'b0}, // R9 level holds
    '{4'd7, 1'b1,1'b0,1'b1,1'b0, 8'h42, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b1,1'b0}, // R7 overrun
    '{4'd8, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'hC042, 1'b0,1'b0}, // R8 full word
    '{4'd8, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'h0042, 1'b0,1'b0}, // R8 high byte cleared
    '{4'd10,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b1,1'b0, 16'h0000, 16'h0000, 1'b0,1'b0}, // R10 enable off
    '{4'd4, 1'b1,1'b0,1'b0,1'b0, 8'hC1, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b0,1'b0}, // R4 7-bit, no irq
    '{4'd10,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b1,1'b0, 16'h0040, 16'h0000, 1'b1,1'b0}, // R10 enable with ready
    '{4'd10,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b1,1'b0, 16'h0000, 16'h0000, 1'b0,1'b0}, // R10 enable off drops
    '{4'd12,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b1,1'b0, 16'h1234, 16'h0000, 1'b0,1'b0}, // R12 data write
    '{4'd11,1'b1,1'b0,1'b1,1'b0, 8'hD5, 1'b1,1'b0,1'b1, 16'h0000, 16'h0041, 1'b0,1'b0}, // R11 old word (R4,R12)
    '{4'd11,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0,1'b1, 16'h0000, 16'h0080, 1'b0,1'b0}, // R11 ready kept
    '{4'd11,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'h00D5, 1'b0,1'b0}, // R11 no overrun
    '{4'd4, 1'b1,1'b0,1'b1,1'b0, 8'hFF, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b0,1'b0}, // R4 8-bit
    '{4'd4, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'h00FF, 1'b0,1'b0}, // R4 bit 7 kept
    '{4'd10,1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b1,1'b0, 16'h0040, 16'h0000, 1'b0,1'b0}, // R10 enable, not ready
    '{4'd6, 1'b1,1'b1,1'b1,1'b1, 8'h33, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b1,1'b1}, // R6 break halts
    '{4'd6, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b1,1'b0}, // R6 one cycle
    '{4'd5, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'hA400, 1'b0,1'b0}, // R5 break word
    '{4'd6, 1'b1,1'b1,1'b1,1'b0, 8'h77, 1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 1'b1,1'b0}, // R6 halt gated
    '{4'd5, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'hA400, 1'b0,1'b0}, // R5 fixed pattern
    '{4'd8, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b1,1'b0,1'b1, 16'h0000, 16'h0000, 1'b0,1'b0}  // R8 break cleared
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, brk = 1'b0, m8 = 1'b1, hen = 1'b0;
  logic [7:0]  d = '0;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        irq, halt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  con_rx_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(vld), .rx_data_i(d),
    .rx_break_i(brk), .mode_8b_i(m8), .halt_en_i(hen), .reg_sel_i(sel),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .irq_o(irq), .halt_o(halt)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    vld = 1'b0; brk = 1'b0; wr = 1'b0; rd = 1'b0; sel = 1'b0; wd = '0; d = '0;
  endtask

  initial begin
    idle();
    #(3*CLK_PERIOD);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      vld = VECS[i].vld; brk = VECS[i].brk; m8 = VECS[i].m8; hen = VECS[i].hen;
      d = VECS[i].d; sel = VECS[i].sel; wr = VECS[i].wr; rd = VECS[i].rd; wd = VECS[i].wd;
      #1;
      if (VECS[i].rd)
        check($sformatf("R%0d v%0d rdata", VECS[i].req, i), rdata, VECS[i].erd);
      @(posedge clk); #1;
      idle();
      check($sformatf("R%0d v%0d irq", VECS[i].req, i), {15'd0, irq}, {15'd0, VECS[i].eirq});
      check($sformatf("R%0d v%0d halt", VECS[i].req, i), {15'd0, halt}, {15'd0, VECS[i].ehalt});
    end

    // R1: reset in the middle of activity
    @(negedge clk); sel = 1'b0; wr = 1'b1; wd = 16'h0040;
    @(negedge clk); idle(); vld = 1'b1; d = 8'h55; brk = 1'b1; hen = 1'b1;
    @(negedge clk); idle(); hen = 1'b0;
    check("R1 irq before reset", {15'd0, irq}, 16'h0001);
    #2 rst_n = 1'b0;
    #3;
    check("R1 irq in reset", {15'd0, irq}, 16'h0000);
    check("R1 halt in reset", {15'd0, halt}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); sel = 1'b0; rd = 1'b1; #1;
    check("R1 status after reset", rdata, 16'h0000);
    @(negedge clk); sel = 1'b1; rd = 1'b1; #1;
    check("R1 data after reset", rdata, 16'h0000);
    @(negedge clk); idle();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(5000*CLK_PERIOD);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule